// File: doc/BRIEF.md
# Gated Pulse-Density Accumulator

This block turns the one-bit output stream of a sigma-delta motion sensor into signed samples. It counts over a gate window of N reference-clock cycles, and at the end of each window it presents one signed sample with a one-cycle strobe. The window length sets the trade between resolution and bandwidth. A longer window gives a finer step per count but fewer samples per second. One count step is worth the span times the sample rate divided by the clock rate. Zero input corresponds to a pulse rate of half the clock.

Two ways of reading the stream are offered. In count mode, the block counts the cycles in which the pulse input is high and removes the midscale offset N/2, so it needs only the pulse line. In up/down mode, the block adds one for every cycle in which the direction line is high and subtracts one for every cycle in which it is low. For the same stream, this gives twice the count-mode result with no offset step. Windows follow each other with no gap, so every input cycle lands in exactly one sample.

Top module: `pdm_gate_accum`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sample_valid_o` is 0 and `sample_o` is 0.
- R2: `sample_valid_o` is high for exactly one cycle per window. For a window whose first input cycle is captured at rising edge k, the strobe is visible after edge k+N-1.
- R3: In count mode (`mode_i` = 0), the sample equals the number of window cycles with `pulse_i` high, minus N/2.
- R4: In up/down mode (`mode_i` = 1), the sample equals the number of window cycles with `dir_i` high minus the number with `dir_i` low.
- R5: Count mode ignores `dir_i`, and up/down mode ignores `pulse_i`.
- R6: `win_len_i` and `mode_i` are captured only in the first cycle of a window. Changes later in the window have no effect on that window's length or result.
- R7: The effective window length is `win_len_i` with bit 0 cleared, raised to 16 when below 16 and limited to 65536 when above it.
- R8: Windows run back to back with no gap. The next window's first input is captured in the cycle right after the last cycle of the previous window.
- R9: Samples are two's complement, 18 bits wide. A saturated window gives exactly +N/2 or -N/2 in count mode and +N or -N in up/down mode, including +65536 at N = 65536.
- R10: `sample_o` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Pulse-density bit used in count mode |
| dir_i | input | 1 | Direction bit used in up/down mode |
| mode_i | input | 1 | 0 = count with offset removal, 1 = up/down |
| win_len_i | input | 17 | Requested window length in cycles |
| sample_o | output | 18 | Signed result of the last completed window |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The stream is driven with five densities: all low, all high, every other cycle, one cycle in four and three cycles in four. Each density is run in both modes. The two saturated densities pin the full-scale ends. The alternating density must land at zero in both modes, which exposes a wrong midscale offset. The quarter densities give asymmetric values, which tell a sign error apart from an off-by-one in the window length. The unused input is driven as the complement of the used one, and `win_len_i` and `mode_i` are changed in every cycle after the first, so leakage from either shows up as a wrong total or an early strobe. Requested lengths of 0, 4, 17 and 70000 test the length limits, and a reset part-way through a window tests the restart.

// File: rtl/pga_pkg.sv
package pga_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_UPDN  = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/pga_gate_timer.sv
module pga_gate_timer #(
    parameter int MIN_WIN = 16,
    parameter int MAX_WIN = 65536,
    parameter int WIN_W   = $clog2(MAX_WIN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIN_W-1:0]      win_len_i,
    input  logic                  mode_i,
    output logic                  start_o,
    output logic                  last_o,
    output logic [WIN_W-1:0]      len_o,
    output pga_pkg::acc_mode_e    mode_o
);
    import pga_pkg::*;

    localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(MIN_WIN);
    localparam logic [WIN_W-1:0] MAX_LEN = WIN_W'(MAX_WIN);

    typedef struct packed {
        logic [WIN_W-1:0] tcnt;
        logic [WIN_W-1:0] len;
        acc_mode_e        mode;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // Round a requested length to an even value inside the legal range.
    function automatic logic [WIN_W-1:0] legal_len(input logic [WIN_W-1:0] req);
        logic [WIN_W-1:0] even;
        even = {req[WIN_W-1:1], 1'b0};
        if (even < MIN_LEN)      return MIN_LEN;
        else if (even > MAX_LEN) return MAX_LEN;
        else                     return even;
    endfunction

    logic             start;
    logic             last;
    logic [WIN_W-1:0] eff_len;
    acc_mode_e        eff_mode;

    always_comb begin
        start    = (tmr_q.tcnt == '0);
        eff_len  = start ? legal_len(win_len_i) : tmr_q.len;
        eff_mode = start ? acc_mode_e'(mode_i) : tmr_q.mode;
        last     = (tmr_q.tcnt == (eff_len - 1'b1));

        tmr_d      = tmr_q;
        tmr_d.len  = eff_len;
        tmr_d.mode = eff_mode;
        tmr_d.tcnt = last ? '0 : tmr_q.tcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{tcnt: '0, len: MIN_LEN, mode: MODE_COUNT};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign start_o = start;
    assign last_o  = last;
    assign len_o   = eff_len;
    assign mode_o  = eff_mode;

endmodule

// File: rtl/pga_step_decode.sv
module pga_step_decode #(
    parameter int WIN_W = 17,
    parameter int ACC_W = WIN_W + 1
) (
    input  pga_pkg::acc_mode_e        mode_i,
    input  logic [WIN_W-1:0]          len_i,
    input  logic                      pulse_i,
    input  logic                      dir_i,
    output logic signed [ACC_W-1:0]   step_o,
    output logic signed [ACC_W-1:0]   base_o
);
    import pga_pkg::*;

    localparam logic signed [ACC_W-1:0] ONE_P = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] ONE_N = -ACC_W'(1);

    logic [ACC_W-1:0] half_len;

    always_comb begin
        half_len = {{(ACC_W-WIN_W+1){1'b0}}, len_i[WIN_W-1:1]};
        if (mode_i == MODE_UPDN) begin
            step_o = dir_i ? ONE_P : ONE_N;
            base_o = '0;
        end else begin
            step_o = pulse_i ? ONE_P : '0;
            base_o = -$signed(half_len);
        end
    end

endmodule

// File: rtl/pga_integrator.sv
module pga_integrator #(
    parameter int ACC_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      last_i,
    input  logic signed [ACC_W-1:0]   base_i,
    input  logic signed [ACC_W-1:0]   step_i,
    output logic signed [ACC_W-1:0]   sample_o,
    output logic                      valid_o
);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] sample;
        logic                    valid;
    } int_t;

    int_t int_d, int_q;

    always_comb begin
        int_d        = int_q;
        int_d.acc    = (start_i ? base_i : int_q.acc) + step_i;
        int_d.sample = last_i ? int_d.acc : int_q.sample;
        int_d.valid  = last_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
        end else begin
            int_q <= int_d;
        end
    end

    assign sample_o = int_q.sample;
    assign valid_o  = int_q.valid;

endmodule

// File: rtl/pdm_gate_accum.sv
module pdm_gate_accum #(
    parameter int MIN_WIN = 16,
    parameter int MAX_WIN = 65536,
    localparam int WIN_W  = $clog2(MAX_WIN + 1),
    localparam int ACC_W  = WIN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             dir_i,
    input  logic             mode_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic [ACC_W-1:0] sample_o,
    output logic             sample_valid_o
);
    import pga_pkg::*;

    logic                    win_start;
    logic                    win_last;
    logic [WIN_W-1:0]        win_len;
    acc_mode_e               win_mode;
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] sample_s;

    pga_gate_timer #(
        .MIN_WIN (MIN_WIN),
        .MAX_WIN (MAX_WIN),
        .WIN_W   (WIN_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_len_i (win_len_i),
        .mode_i    (mode_i),
        .start_o   (win_start),
        .last_o    (win_last),
        .len_o     (win_len),
        .mode_o    (win_mode)
    );

    pga_step_decode #(
        .WIN_W (WIN_W),
        .ACC_W (ACC_W)
    ) u_step (
        .mode_i  (win_mode),
        .len_i   (win_len),
        .pulse_i (pulse_i),
        .dir_i   (dir_i),
        .step_o  (step),
        .base_o  (base)
    );

    pga_integrator #(
        .ACC_W (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (win_start),
        .last_i   (win_last),
        .base_i   (base),
        .step_i   (step),
        .sample_o (sample_s),
        .valid_o  (sample_valid_o)
    );

    assign sample_o = sample_s;

endmodule

// File: rtl/pdm_gate_accum_chk.sv
module pdm_gate_accum_chk #(
    parameter int MIN_WIN = 16,
    parameter int MAX_WIN = 65536,
    localparam int WIN_W  = $clog2(MAX_WIN + 1),
    localparam int ACC_W  = WIN_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] sample_o,
    input logic             sample_valid_o
);

    // Cycles seen since the last strobe, saturating.
    logic [WIN_W:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (sample_valid_o)   gap_q <= '0;
        else if (gap_q != '1)      gap_q <= gap_q + 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!sample_valid_o && sample_o == '0)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o); // R2

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> (gap_q >= (WIN_W+1)'(MIN_WIN - 1))); // R7

    AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> ($signed(sample_o) <= $signed((ACC_W+1)'(MAX_WIN)) &&
                            $signed(sample_o) >= -$signed((ACC_W+1)'(MAX_WIN)))); // R9

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_o |-> $stable(sample_o)); // R10

endmodule

bind pdm_gate_accum pdm_gate_accum_chk #(
    .MIN_WIN (MIN_WIN),
    .MAX_WIN (MAX_WIN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
);

// File: tb/pdm_gate_accum_test.sv
`timescale 1ns/1ps
module pdm_gate_accum_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_i = 1'b0;
    logic        dir_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [16:0] win_len_i = 17'd16;
    logic [17:0] sample_o;
    logic        sample_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    int have_prev = 0;
    int prev_exp  = 0;
    int prev_req  = 0;

    always #2 clk = ~clk;   // 250 MHz

    pdm_gate_accum uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pulse_i        (pulse_i),
        .dir_i          (dir_i),
        .mode_i         (mode_i),
        .win_len_i      (win_len_i),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o)
    );

    typedef struct packed {
        logic        m;      // 0 count (R3), 1 up/down (R4)
        logic [16:0] wl;     // requested length
        int          neff;   // expected effective length (R7)
        int          pat;    // density pattern
        int          exp;    // expected sample
        int          req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 17'd16,    16,    1,  8,     9},
        '{1'b0, 17'd16,    16,    0, -8,     9},
        '{1'b0, 17'd16,    16,    2,  0,     3},
        '{1'b0, 17'd16,    16,    3, -4,     3},
        '{1'b0, 17'd16,    16,    4,  4,     3},
        '{1'b1, 17'd16,    16,    1,  16,    9},
        '{1'b1, 17'd16,    16,    0, -16,    9},
        '{1'b1, 17'd16,    16,    2,  0,     4},
        '{1'b1, 17'd16,    16,    3, -8,     4},
        '{1'b1, 17'd16,    16,    4,  8,     4},
        '{1'b0, 17'd100,   100,   3, -25,    6},
        '{1'b1, 17'd100,   100,   4,  50,    6},
        '{1'b0, 17'd17,    16,    1,  8,     7},
        '{1'b1, 17'd4,     16,    0, -16,    7},
        '{1'b0, 17'd0,     16,    4,  4,     7},
        '{1'b1, 17'd70000, 65536, 1,  65536, 9}
    };

    function automatic logic pat_bit(input int p, input int k);
        case (p)
            0: return 1'b0;
            1: return 1'b1;
            2: return k[0];
            3: return (k % 4) == 0;
            default: return (k % 4) != 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at the negedge after the last edge of a window.
    task automatic check_strobe();
        check(sample_valid_o === 1'b1, "R2", "strobe after last window cycle",
              int'(sample_valid_o), 1);
        check($signed(sample_o) == prev_exp, $sformatf("R%0d", prev_req),
              "window result (R8 back-to-back)", int'($signed(sample_o)), prev_exp);
    endtask

    // One full window; the unused input is the complement of the used one (R5),
    // and win_len_i / mode_i are disturbed after the first cycle (R6).
    task automatic run_win(input logic m, input logic [16:0] wl, input int neff,
                           input int pat, input int exp, input int req);
        for (int k = 0; k < neff; k++) begin
            @(negedge clk);
            if (k == 0 && have_prev != 0) check_strobe();
            if (k == 1) begin
                check(sample_valid_o === 1'b0, "R2", "strobe one cycle wide",
                      int'(sample_valid_o), 0);
                if (have_prev != 0)
                    check($signed(sample_o) == prev_exp, "R10", "sample held",
                          int'($signed(sample_o)), prev_exp);
            end
            if (k == neff - 1)
                check(sample_valid_o === 1'b0, "R6", "no early strobe",
                      int'(sample_valid_o), 0);
            rst_n = 1'b1;
            if (k == 0) begin
                mode_i    = m;
                win_len_i = wl;
            end else begin
                mode_i    = ~m;
                win_len_i = 17'd40;
            end
            if (m) begin
                dir_i   = pat_bit(pat, k);
                pulse_i = ~dir_i;
            end else begin
                pulse_i = pat_bit(pat, k);
                dir_i   = ~pulse_i;
            end
        end
        have_prev = 1;
        prev_exp  = exp;
        prev_req  = req;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(sample_valid_o === 1'b0, "R1", "valid in reset", int'(sample_valid_o), 0);
        check(sample_o === '0, "R1", "sample in reset", int'($signed(sample_o)), 0);

        // Vector table: R3, R4, R5, R6, R7, R8, R9 windows back to back
        for (int i = 0; i < NV; i++)
            run_win(VEC[i].m, VEC[i].wl, VEC[i].neff, VEC[i].pat, VEC[i].exp, VEC[i].req);
        @(negedge clk);
        check_strobe();

        // Reset in the middle of a window (R1), then a clean restart
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            mode_i = 1'b0; win_len_i = 17'd16; pulse_i = 1'b1; dir_i = 1'b0;
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(sample_valid_o === 1'b0, "R1", "valid after mid-window reset",
              int'(sample_valid_o), 0);
        check(sample_o === '0, "R1", "sample after mid-window reset",
              int'($signed(sample_o)), 0);
        have_prev = 0;
        run_win(1'b0, 17'd16, 16, 1, 8, 9);
        @(negedge clk);
        check_strobe();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule